// File: doc/BRIEF.md
# Frame-Aligned Serial Word Transmitter

This block turns parallel words into a serial bit stream on a single data pin. Each transfer is lined up with a frame-sync pulse. A word is handed in through a valid/ready handshake and parked in a staging register. Between frames it moves into the transmit word register. When a frame starts, the word leaves most significant bit first, one bit per bit-clock cycle. When the word is finished, the pin driver is released.

The gap between frame start and the first data bit is picked by a 2-bit select: zero, one or two bit clocks. The fourth code is reserved. With zero gap, the first bit comes straight off the preloaded transmit register, through a combinational path. It is on the pin in the same cycle that frame sync is high. With a two-clock gap, the slot before the data is driven low, in the position of a framing bit. The word length can be set from 1 bit up to the parallel width.

If a frame starts and no fresh word is waiting, the block raises a one-cycle underrun pulse and sends the previous word again.

Top module: `fs_serial_tx`

The control machine has three states:
- `ST_IDLE`: no word is being sent; the pin is released unless a zero-gap frame is starting.
- `ST_FRAMEBIT`: the low framing slot of the two-clock gap.
- `ST_SHIFT`: data bits go out, counting down to bit 0.

Its transitions are:
- `ST_IDLE` to `ST_SHIFT` on frame start with a one-clock gap, or with zero gap and a word longer than one bit.
- `ST_IDLE` to `ST_FRAMEBIT` on frame start with a two-clock gap.
- `ST_IDLE` to `ST_IDLE` on a zero-gap start of a 1-bit word.
- `ST_FRAMEBIT` to `ST_SHIFT` always.
- `ST_SHIFT` to `ST_IDLE` after bit 0.

## Requirements
- R1: While reset is low and in the first cycle after it, tx_oe, tx_data, word_done and underrun are 0 and wr_ready is 1.
- R2: A word is taken on a rising edge where wr_valid and wr_ready are both 1. While a staged word waits behind an unsent transmit word, wr_ready stays 0.
- R3: A frame starts at a rising edge where fsync is sampled 1 after having been 0 on the previous edge, and the block is idle. fsync held high, or pulsed while a word is being sent, starts nothing.
- R4: Delay select 2'b00: in the cycle where fsync is high at frame start, tx_oe is 1 and tx_data already carries the word's first bit. This is combinational, before the starting edge.
- R5: Delay select 2'b01: the first bit is driven in the cycle after the starting edge.
- R6: Delay select 2'b10: the cycle after the starting edge drives tx_oe=1 with tx_data=0, and the first bit follows one cycle later.
- R7: Delay select 2'b11 is reserved. A frame sync then drives nothing, consumes no word and raises no underrun.
- R8: With wlen_m1 = N, bits N down to 0 of the word are sent, bit N first, one per cycle. Bits above N are ignored.
- R9: In the cycle after the last bit, word_done is 1 for exactly one cycle and tx_oe is 0 unless a new zero-gap frame starts. tx_oe stays 0 until the next frame.
- R10: A frame start with no fresh word pulses underrun for one cycle, in the cycle after the starting edge. The word sent previously is sent again.
- R11: A zero-gap frame may start in the word_done cycle of the previous word. The staged word's first bit then appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all transitions on its rising edge |
| rst_n | input | 1 | Active-low reset |
| fsync | input | 1 | Frame-sync input |
| dly_sel | input | 2 | Gap select: 00 zero, 01 one, 10 two bit clocks, 11 reserved |
| wlen_m1 | input | LEN_W | Word length minus one |
| wr_valid | input | 1 | Parallel word offered |
| wr_data | input | WORD_W | Parallel word, right-justified |
| wr_ready | output | 1 | Staging register free |
| tx_data | output | 1 | Serial data out |
| tx_oe | output | 1 | Output enable for tx_data (0 = high impedance) |
| word_done | output | 1 | One-cycle pulse after the last bit |
| underrun | output | 1 | One-cycle pulse on a frame with no fresh word |

## Verification
The end of one word and the zero-gap start of the next can share one cycle. In that cycle, word_done from the old word coincides with the combinational first bit of the staged word. The bench provokes this by staging a second word behind the first and raising fsync exactly in the done cycle. It then expects word_done=1, tx_oe=1 and the new word's MSB in that same cycle, followed by the rest of the new word with no underrun. A separate case, where no second word is staged, must raise underrun in the cycle after the start.

// File: rtl/fstx_pkg.sv
`timescale 1ns/1ps
package fstx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FRAMEBIT = 2'd1,
        ST_SHIFT    = 2'd2
    } fstx_state_e;

    typedef enum logic [1:0] {
        DLY_ZERO = 2'd0,
        DLY_ONE  = 2'd1,
        DLY_TWO  = 2'd2,
        DLY_RSVD = 2'd3
    } fstx_dly_e;

endpackage

// File: rtl/fstx_hold.sv
`timescale 1ns/1ps
// Staging register for the next parallel word.
module fstx_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic              wr_ready,
    output logic              hold_full,
    output logic [WORD_W-1:0] hold_data
);

    assign wr_ready = ~hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // A parked word is neither lost nor overwritten until it is taken.
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full && !take |=> hold_full && $stable(hold_data));

endmodule

// File: rtl/fstx_word.sv
`timescale 1ns/1ps
// Transmit word register with its fresh flag and bit selection.
module fstx_word #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              start,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_data,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic [LEN_W-1:0]  idx,
    output logic              fresh,
    output logic              first_bit,
    output logic              cur_bit
);

    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] first_word;

    // At a frame start the word is either the preloaded one or, when the
    // staged word has not moved yet, taken straight from staging.
    assign first_word = (!fresh && hold_full) ? hold_data : cur_q;
    assign first_bit  = first_word[wlen_m1];
    assign cur_bit    = cur_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            fresh <= 1'b0;
        end else begin
            if (take) cur_q <= hold_data;
            if (start)     fresh <= 1'b0;
            else if (take) fresh <= 1'b1;
        end
    end

    // An unsent word stays put until a frame consumes it.
    assert_word_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fresh && !start |=> fresh && $stable(cur_q));

endmodule

// File: rtl/fstx_ctrl.sv
`timescale 1ns/1ps
// Frame detection, gap sequencing, bit counter and pin drive.
module fstx_ctrl
    import fstx_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [1:0]       dly_sel,
    input  logic [LEN_W-1:0] wlen_m1,
    input  logic             fresh,
    input  logic             hold_full,
    input  logic             first_bit,
    input  logic             cur_bit,
    output logic             start,
    output logic             take,
    output logic [LEN_W-1:0] idx,
    output logic             tx_data,
    output logic             tx_oe,
    output logic             word_done,
    output logic             underrun
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    fstx_state_e state_q, state_d;
    fstx_dly_e   dly;
    logic        fs_prev_q;
    logic        zero_start;
    logic        last_bit;

    assign dly        = fstx_dly_e'(dly_sel);
    assign start      = fsync && !fs_prev_q && (state_q == ST_IDLE) && (dly != DLY_RSVD);
    assign zero_start = start && (dly == DLY_ZERO);
    assign take       = (state_q == ST_IDLE) && hold_full && !fresh;
    assign last_bit   = (state_q == ST_SHIFT) && (idx == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    case (dly)
                        DLY_ZERO: state_d = (wlen_m1 == '0) ? ST_IDLE : ST_SHIFT;
                        DLY_ONE:  state_d = ST_SHIFT;
                        DLY_TWO:  state_d = ST_FRAMEBIT;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FRAMEBIT: state_d = ST_SHIFT;
            ST_SHIFT:    if (last_bit) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Bit counter and frame-sync history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            fs_prev_q <= 1'b0;
        end else begin
            fs_prev_q <= fsync;
            if (start)
                idx <= (dly == DLY_ZERO) ? wlen_m1 - ONE : wlen_m1;
            else if (state_q == ST_SHIFT && !last_bit)
                idx <= idx - ONE;
        end
    end

    // Registered event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_done <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            word_done <= last_bit || (zero_start && wlen_m1 == '0);
            underrun  <= start && !fresh && !hold_full;
        end
    end

    // Pin drive
    always_comb begin
        tx_oe   = 1'b0;
        tx_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (zero_start) begin
                    tx_oe   = 1'b1;
                    tx_data = first_bit;
                end
            end
            ST_FRAMEBIT: begin
                tx_oe   = 1'b1;
                tx_data = 1'b0;
            end
            ST_SHIFT: begin
                tx_oe   = 1'b1;
                tx_data = cur_bit;
            end
            default: ;
        endcase
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(tx_oe));

    assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && (dly_sel == 2'b11) |-> !tx_oe);

    assert_framebit_then_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAMEBIT) |=> (state_q == ST_SHIFT));

    assert_underrun_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

// File: rtl/fs_serial_tx.sv
`timescale 1ns/1ps
module fs_serial_tx #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [1:0]        dly_sel,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              word_done,
    output logic              underrun
);

    logic              take;
    logic              start;
    logic              hold_full;
    logic [WORD_W-1:0] hold_data;
    logic              fresh;
    logic              first_bit;
    logic              cur_bit;
    logic [LEN_W-1:0]  idx;

    fstx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .take      (take),
        .wr_ready  (wr_ready),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    fstx_word #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .start     (start),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .wlen_m1   (wlen_m1),
        .idx       (idx),
        .fresh     (fresh),
        .first_bit (first_bit),
        .cur_bit   (cur_bit)
    );

    fstx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .dly_sel   (dly_sel),
        .wlen_m1   (wlen_m1),
        .fresh     (fresh),
        .hold_full (hold_full),
        .first_bit (first_bit),
        .cur_bit   (cur_bit),
        .start     (start),
        .take      (take),
        .idx       (idx),
        .tx_data   (tx_data),
        .tx_oe     (tx_oe),
        .word_done (word_done),
        .underrun  (underrun)
    );

endmodule

// File: tb/tb_fs_serial_tx.sv
`timescale 1ns/1ps
module tb_fs_serial_tx;

    localparam int W  = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic [1:0]    dly_sel = 2'd1;
    logic [LW-1:0] wlen_m1 = 4'd7;
    logic          wr_valid = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_ready, tx_data, tx_oe, word_done, underrun;

    int n_tests = 0;
    int n_fail  = 0;

    fs_serial_tx #(.WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .dly_sel(dly_sel),
        .wlen_m1(wlen_m1), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx_data(tx_data), .tx_oe(tx_oe),
        .word_done(word_done), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    // {delay select, word length minus one, word}
    localparam logic [21:0] VEC [8] = '{
        {2'd1, 4'd7,  16'h00A5},
        {2'd0, 4'd7,  16'h003C},
        {2'd2, 4'd7,  16'h0096},
        {2'd1, 4'd15, 16'hBEEF},
        {2'd0, 4'd15, 16'h8001},
        {2'd2, 4'd3,  16'h000B},
        {2'd1, 4'd0,  16'h0001},
        {2'd0, 4'd1,  16'hFFFD}
    };

    task automatic step(input logic fs, input logic e_oe, input logic e_data,
                        input logic e_done, input logic e_under, input string tag);
        @(negedge clk);
        fsync = fs;
        #1;
        n_tests++;
        if (tx_oe !== e_oe || (e_oe && tx_data !== e_data) ||
            word_done !== e_done || underrun !== e_under) begin
            n_fail++;
            $display("FAIL %s: oe,data,done,under = %b%b%b%b expected %b%b%b%b",
                     tag, tx_oe, tx_data, word_done, underrun,
                     e_oe, e_data, e_done, e_under);
        end
    endtask

    task automatic check_ready(input logic exp, input string tag);
        n_tests++;
        if (wr_ready !== exp) begin
            n_fail++;
            $display("FAIL %s: wr_ready = %b expected %b", tag, wr_ready, exp);
        end
    endtask

    task automatic write_word(input logic [W-1:0] w);
        @(negedge clk);
        fsync    = 1'b0;
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic run_frame(input int d, input int wl, input logic [W-1:0] word,
                             input logic e_under, input logic held, input int pulse_at,
                             input logic started, input logic chain,
                             input logic chain_msb, input string tag);
        int nb;
        int last;
        nb   = wl + 1;
        last = d + nb;
        for (int k = (started ? 1 : 0); k <= last; k++) begin
            logic fs, eo, ed, edn, eu;
            int j;
            j   = k - d;
            fs  = (k == 0) || held || (pulse_at > 0 && k == pulse_at);
            eo  = 1'b0;
            ed  = 1'b0;
            edn = 1'b0;
            eu  = (k == 1) && e_under;
            if (j >= 0 && j < nb) begin
                eo = 1'b1;
                ed = word[wl-j];
            end else if (k >= 1 && k < d) begin
                eo = 1'b1;
                ed = 1'b0;
            end
            if (j == nb) begin
                edn = 1'b1;
                if (chain) begin
                    fs = 1'b1;
                    eo = 1'b1;
                    ed = chain_msb;
                end
            end
            step(fs, eo, ed, edn, eu, tag);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 in reset");
        check_ready(1'b1, "R1 in reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 after reset");
        check_ready(1'b1, "R1 after reset");

        // Table walk: R4 R5 R6 R8 R9
        for (int v = 0; v < 8; v++) begin
            int d;
            int wl;
            d       = int'(VEC[v][21:20]);
            wl      = int'(VEC[v][19:16]);
            dly_sel = VEC[v][21:20];
            wlen_m1 = VEC[v][19:16];
            write_word(VEC[v][15:0]);
            idle(2, "R9 idle before frame");
            if (d == 0)
                run_frame(d, wl, VEC[v][15:0], 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R4 R8 R9 vector");
            else if (d == 1)
                run_frame(d, wl, VEC[v][15:0], 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R5 R8 R9 vector");
            else
                run_frame(d, wl, VEC[v][15:0], 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 R8 R9 vector");
            idle(1, "R9 released after word");
        end

        // R10: no fresh word, last word (bits 1..0 of FFFD) goes again
        dly_sel = 2'd1;
        wlen_m1 = 4'd1;
        run_frame(1, 1, 16'hFFFD, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R10 underrun resend");
        idle(1, "R10 after");

        // R7: reserved select ignores frame sync and keeps the word
        wlen_m1 = 4'd7;
        write_word(16'h005A);
        idle(2, "R7 preload");
        dly_sel = 2'd3;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 reserved sync");
        idle(3, "R7 reserved silent");
        check_ready(1'b1, "R7 staging empty");
        dly_sel = 2'd1;
        run_frame(1, 7, 16'h005A, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7 word kept");
        idle(1, "R7 after");

        // R3: held sync and a mid-word pulse start nothing new
        write_word(16'h00C3);
        idle(2, "R3 preload");
        dly_sel = 2'd2;
        run_frame(2, 7, 16'h00C3, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R3 held sync");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 no restart while held");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 sync dropped");
        write_word(16'h0071);
        idle(2, "R3 preload 2");
        dly_sel = 2'd1;
        run_frame(1, 7, 16'h0071, 1'b0, 1'b0, 4, 1'b0, 1'b0, 1'b0, "R3 mid-word pulse");
        idle(2, "R3 no late start");

        // R2 and R11: staged word behind an unsent one, back-to-back zero gap
        dly_sel = 2'd0;
        write_word(16'h0069);
        idle(2, "R2 first preload");
        check_ready(1'b1, "R2 staging free");
        write_word(16'h00D2);
        idle(1, "R2 staged");
        check_ready(1'b0, "R2 staging held");
        run_frame(0, 7, 16'h0069, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b1, "R11 first word");
        run_frame(0, 7, 16'h00D2, 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R11 chained word");
        idle(1, "R11 after");
        check_ready(1'b1, "R2 staging freed");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule